// File: doc/BRIEF.md
# Channel Status Triple Block Buffer

This block holds the channel-status bits of a two-channel AES3 link, one whole 192-frame block at a time. It keeps three stores, each sized for both channels. The capture store fills one bit per frame from the receive side. The host store gets whole blocks from the capture store, and software can read and change it through a byte-wide register window. The transmit store gets whole blocks from the host store and is the only source of the bits sent on the transmit side. Every block copy is one clock cycle wide and happens on a block-start frame.

Block-start frames (the Z preamble) set the timing of both copies. The receive side marks them with `rx_blk_start`, and the capture-to-host copy fires there, but only once a complete block has been captured. The transmit side marks them with `tx_blk_start`, and the host-to-transmit copy fires on that request. Each copy path has a hold input that drops the copy at that boundary. Each copy path also has a sticky event flag with its own enable. Any enabled flag that is set drives `irq`.

The receive sequencer has three states. HUNT waits for the first block start. FILL writes frames into the capture store. FULL means a complete block is waiting for the next start. Its transitions are: HUNT→FILL on a start frame; FILL→FILL on a start frame, which restarts the fill at frame 0; FILL→FULL when frame 191 is written; FULL→FILL on a start frame, which is also the moment of the copy. The transmit sequencer has two states. IDLE means no block has been started yet. RUN means frames are being served. It moves IDLE→RUN on the first start request and then stays in RUN, where each start request resets the frame pointer.

Top module: `chstat_blkbuf`

## Requirements
- R1: After reset all three stores, `evt_stat`, `irq`, `tx_ch_a` and `tx_ch_b` are zero.
- R2: Each `rx_valid` frame after a start frame is written into the capture store at the next frame index. When 192 frames have been captured, the next `rx_valid` frame with `rx_blk_start=1` and `hold_rx2host=0` copies the whole capture store into the host store. The copy is visible on `host_rdata` in the next cycle, and that start frame becomes frame 0 of the new capture.
- R3: Frames received before the first start frame are ignored. A start frame that arrives before 192 frames have been captured makes no copy and restarts the capture at frame 0.
- R4: Address 32+k reads byte k of channel A and address 56+k reads byte k of channel B, for k = 0..23. Bit 7 of a byte is frame 8k and bit 0 is frame 8k+7. Address 32 bit 7 is therefore the first (consumer/professional) bit of the block. The read is combinational.
- R5: Addresses below 32 or above 79 read as 0, and writes to them change no store.
- R6: While `run_en=0`, `host_rdata` is 0 and `host_wr` is ignored.
- R7: A host write updates its byte of the host store in the next cycle. If a capture-to-host copy happens in the same cycle, the copy wins.
- R8: A `tx_frame_req` with `tx_blk_start=1` and `hold_host2tx=0` copies the host store into the transmit store. The next cycle's `tx_ch_a`/`tx_ch_b` then carry frame 0 of the copied block. Each later request without a start carries the next frame, wrapping from 191 to 0. Requests before the first start request output 0.
- R9: A copy suppressed by its hold input is dropped and not deferred. The destination store and its event flag stay unchanged, and the transmit side keeps serving the old transmit store.
- R10: `evt_stat[0]` is set by a capture-to-host copy and `evt_stat[1]` by a host-to-transmit copy. Each stays set until an `evt_clr` pulse with 1 in its position clears it, and a set in the same cycle as a clear wins.
- R11: `irq` is high exactly when some bit is set in both `evt_stat` and `evt_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Global run control; host access allowed only when 1 |
| rx_valid | input | 1 | One received frame's channel-status bits present |
| rx_blk_start | input | 1 | Received frame is a block start (Z preamble) |
| rx_ch_a | input | 1 | Received channel A status bit |
| rx_ch_b | input | 1 | Received channel B status bit |
| tx_frame_req | input | 1 | Transmitter requests the next frame's bits |
| tx_blk_start | input | 1 | Requested frame is a transmit block start |
| tx_ch_a | output | 1 | Transmitted channel A status bit (registered) |
| tx_ch_b | output | 1 | Transmitted channel B status bit (registered) |
| host_addr | input | 7 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| hold_rx2host | input | 1 | Suppress capture-to-host copies |
| hold_host2tx | input | 1 | Suppress host-to-transmit copies |
| evt_en | input | 2 | Interrupt enables: bit 0 capture-to-host, bit 1 host-to-transmit |
| evt_clr | input | 2 | Write-1-to-clear pulses for `evt_stat` |
| evt_stat | output | 2 | Sticky copy event flags |
| irq | output | 1 | Active-high interrupt |

## Verification
A wrong receive-sequencer state shows up as a missing or extra copy. That appears on `evt_stat[0]` one cycle after the start frame, and in the bytes read from the host window in the same cycle. A wrong capture index or a wrong transmit pointer shows up as misplaced bits. The bench catches these by sweeping every byte of the host window against a computed pattern, and by comparing every transmitted frame, including the wrap, one cycle after each request. Faults in hold handling and address decoding appear at once as store contents that changed, or as nonzero reads where zero is required.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

    localparam int unsigned CS_BLK_BITS = 192;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_FILL,
        RX_FULL
    } rx_state_t;

    typedef enum logic {
        TX_IDLE,
        TX_RUN
    } tx_state_t;

endpackage

// File: rtl/chstat_rx_fill.sv
module chstat_rx_fill
    import chstat_pkg::*;
#(
    parameter int unsigned BLK_BITS = CS_BLK_BITS,
    localparam int unsigned CW = $clog2(BLK_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_valid,
    input  logic                blk_start,
    input  logic                bit_a,
    input  logic                bit_b,
    input  logic                hold,
    output logic [BLK_BITS-1:0] d_a,
    output logic [BLK_BITS-1:0] d_b,
    output logic                xfer
);

    rx_state_t       state, state_nxt;
    logic [CW-1:0]   cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= state_nxt;
    end

    // next state and copy strobe
    always_comb begin
        state_nxt = state;
        xfer      = 1'b0;
        unique case (state)
            RX_HUNT: begin
                if (bit_valid && blk_start) state_nxt = RX_FILL;
            end
            RX_FILL: begin
                if (bit_valid && !blk_start && cnt == CW'(BLK_BITS - 1))
                    state_nxt = RX_FULL;
            end
            RX_FULL: begin
                if (bit_valid && blk_start) begin
                    state_nxt = RX_FILL;
                    xfer      = !hold;
                end
            end
            default: state_nxt = RX_HUNT;
        endcase
    end

    // capture store and frame index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_a <= '0;
            d_b <= '0;
            cnt <= '0;
        end else if (bit_valid) begin
            if (blk_start) begin
                d_a[0] <= bit_a;
                d_b[0] <= bit_b;
                cnt    <= CW'(1);
            end else if (state == RX_FILL) begin
                d_a[cnt] <= bit_a;
                d_b[cnt] <= bit_b;
                cnt      <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/chstat_host_store.sv
module chstat_host_store
    import chstat_pkg::*;
#(
    parameter int unsigned BLK_BITS  = CS_BLK_BITS,
    parameter int unsigned BASE_ADDR = 32,
    parameter int unsigned ADDR_W    = 7,
    localparam int unsigned NBYTES   = BLK_BITS / 8,
    localparam int unsigned TOP_ADDR = BASE_ADDR + 2 * NBYTES,
    localparam int unsigned BW       = $clog2(NBYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic                load,
    input  logic [BLK_BITS-1:0] d_a,
    input  logic [BLK_BITS-1:0] d_b,
    output logic [BLK_BITS-1:0] e_a,
    output logic [BLK_BITS-1:0] e_b
);

    logic          hit;
    logic          sel_b;
    int            off;
    logic [BW-1:0] byte_ix;
    logic [7:0]    byt_a [NBYTES];
    logic [7:0]    byt_b [NBYTES];

    // window decode
    always_comb begin
        hit     = run_en && (int'(addr) >= int'(BASE_ADDR)) && (int'(addr) < int'(TOP_ADDR));
        off     = int'(addr) - int'(BASE_ADDR);
        sel_b   = off >= int'(NBYTES);
        byte_ix = '0;
        if (hit) byte_ix = BW'(sel_b ? off - int'(NBYTES) : off);
    end

    // first serial bit of each byte lands in bit 7
    always_comb begin
        for (int k = 0; k < int'(NBYTES); k++) begin
            for (int i = 0; i < 8; i++) begin
                byt_a[k][7-i] = e_a[8*k+i];
                byt_b[k][7-i] = e_b[8*k+i];
            end
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (hit) rdata = sel_b ? byt_b[byte_ix] : byt_a[byte_ix];
    end

    // host store: block copy has priority over a host byte write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_a <= '0;
            e_b <= '0;
        end else if (load) begin
            e_a <= d_a;
            e_b <= d_b;
        end else if (wr && hit) begin
            for (int i = 0; i < 8; i++) begin
                if (sel_b) e_b[int'(byte_ix)*8+i] <= wdata[7-i];
                else       e_a[int'(byte_ix)*8+i] <= wdata[7-i];
            end
        end
    end

endmodule

// File: rtl/chstat_tx_drain.sv
module chstat_tx_drain
    import chstat_pkg::*;
#(
    parameter int unsigned BLK_BITS = CS_BLK_BITS,
    localparam int unsigned CW = $clog2(BLK_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_req,
    input  logic                blk_start,
    input  logic                hold,
    input  logic [BLK_BITS-1:0] e_a,
    input  logic [BLK_BITS-1:0] e_b,
    output logic                tx_a,
    output logic                tx_b,
    output logic                xfer
);

    tx_state_t            state, state_nxt;
    logic [CW-1:0]        ptr;
    logic [BLK_BITS-1:0]  f_a, f_b;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nxt;
    end

    // next state and copy strobe
    always_comb begin
        state_nxt = state;
        xfer      = frame_req && blk_start && !hold;
        unique case (state)
            TX_IDLE: if (frame_req && blk_start) state_nxt = TX_RUN;
            TX_RUN:  state_nxt = TX_RUN;
            default: state_nxt = TX_IDLE;
        endcase
    end

    // transmit store, pointer and registered bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_a  <= '0;
            f_b  <= '0;
            ptr  <= '0;
            tx_a <= 1'b0;
            tx_b <= 1'b0;
        end else begin
            if (xfer) begin
                f_a <= e_a;
                f_b <= e_b;
            end
            if (frame_req) begin
                if (blk_start) begin
                    tx_a <= xfer ? e_a[0] : f_a[0];
                    tx_b <= xfer ? e_b[0] : f_b[0];
                    ptr  <= CW'(1);
                end else if (state == TX_RUN) begin
                    tx_a <= f_a[ptr];
                    tx_b <= f_b[ptr];
                    ptr  <= (ptr == CW'(BLK_BITS - 1)) ? '0 : ptr + 1'b1;
                end else begin
                    tx_a <= 1'b0;
                    tx_b <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/chstat_evt.sv
module chstat_evt #(
    parameter int unsigned NEVT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEVT-1:0] set,
    input  logic [NEVT-1:0] clr,
    input  logic [NEVT-1:0] en,
    output logic [NEVT-1:0] stat,
    output logic            irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat <= '0;
        else        stat <= set | (stat & ~clr);
    end

    always_comb irq = |(stat & en);

endmodule

// File: rtl/chstat_blkbuf.sv
module chstat_blkbuf
    import chstat_pkg::*;
#(
    parameter int unsigned BLK_BITS  = CS_BLK_BITS,
    parameter int unsigned BASE_ADDR = 32,
    parameter int unsigned ADDR_W    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              rx_valid,
    input  logic              rx_blk_start,
    input  logic              rx_ch_a,
    input  logic              rx_ch_b,
    input  logic              tx_frame_req,
    input  logic              tx_blk_start,
    output logic              tx_ch_a,
    output logic              tx_ch_b,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              hold_rx2host,
    input  logic              hold_host2tx,
    input  logic [1:0]        evt_en,
    input  logic [1:0]        evt_clr,
    output logic [1:0]        evt_stat,
    output logic              irq
);

    logic [BLK_BITS-1:0] d_a, d_b, e_a, e_b;
    logic                d2e_fire, e2f_fire;

    chstat_rx_fill #(.BLK_BITS(BLK_BITS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_valid (rx_valid),
        .blk_start (rx_blk_start),
        .bit_a     (rx_ch_a),
        .bit_b     (rx_ch_b),
        .hold      (hold_rx2host),
        .d_a       (d_a),
        .d_b       (d_b),
        .xfer      (d2e_fire)
    );

    chstat_host_store #(
        .BLK_BITS  (BLK_BITS),
        .BASE_ADDR (BASE_ADDR),
        .ADDR_W    (ADDR_W)
    ) u_host (
        .clk   (clk),
        .rst_n (rst_n),
        .run_en(run_en),
        .addr  (host_addr),
        .wr    (host_wr),
        .wdata (host_wdata),
        .rdata (host_rdata),
        .load  (d2e_fire),
        .d_a   (d_a),
        .d_b   (d_b),
        .e_a   (e_a),
        .e_b   (e_b)
    );

    chstat_tx_drain #(.BLK_BITS(BLK_BITS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_req (tx_frame_req),
        .blk_start (tx_blk_start),
        .hold      (hold_host2tx),
        .e_a       (e_a),
        .e_b       (e_b),
        .tx_a      (tx_ch_a),
        .tx_b      (tx_ch_b),
        .xfer      (e2f_fire)
    );

    chstat_evt #(.NEVT(2)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({e2f_fire, d2e_fire}),
        .clr   (evt_clr),
        .en    (evt_en),
        .stat  (evt_stat),
        .irq   (irq)
    );

endmodule

// File: rtl/chstat_blkbuf_chk.sv
module chstat_blkbuf_chk #(
    parameter int unsigned BASE_ADDR = 32,
    parameter int unsigned NBYTES    = 24,
    parameter int unsigned ADDR_W    = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic              rx_valid,
    input logic              rx_blk_start,
    input logic              tx_frame_req,
    input logic              tx_blk_start,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        host_rdata,
    input logic              hold_rx2host,
    input logic              hold_host2tx,
    input logic [1:0]        evt_en,
    input logic [1:0]        evt_clr,
    input logic [1:0]        evt_stat,
    input logic              irq,
    input logic              d2e_fire,
    input logic              e2f_fire
);

    localparam int unsigned TOP_ADDR = BASE_ADDR + 2 * NBYTES;

    // R2
    d2e_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d2e_fire |-> (rx_valid && rx_blk_start));

    // R8
    e2f_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e2f_fire |-> (tx_frame_req && tx_blk_start));

    // R9
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_rx2host |-> !d2e_fire);

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_host2tx |-> !e2f_fire);

    // R10
    d2e_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d2e_fire |=> evt_stat[0]);

    // R10
    e2f_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e2f_fire |=> evt_stat[1]);

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_stat[0] && !evt_clr[0]) |=> evt_stat[0]);

    // R6
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> (host_rdata == 8'h00));

    // R5
    window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(host_addr) < int'(BASE_ADDR)) || (int'(host_addr) >= int'(TOP_ADDR)))
        |-> (host_rdata == 8'h00));

    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_stat & evt_en) != 2'b00) |-> irq);

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_stat & evt_en) == 2'b00) |-> !irq);

endmodule

bind chstat_blkbuf chstat_blkbuf_chk #(
    .BASE_ADDR (BASE_ADDR),
    .NBYTES    (BLK_BITS / 8),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .rx_valid     (rx_valid),
    .rx_blk_start (rx_blk_start),
    .tx_frame_req (tx_frame_req),
    .tx_blk_start (tx_blk_start),
    .host_addr    (host_addr),
    .host_rdata   (host_rdata),
    .hold_rx2host (hold_rx2host),
    .hold_host2tx (hold_host2tx),
    .evt_en       (evt_en),
    .evt_clr      (evt_clr),
    .evt_stat     (evt_stat),
    .irq          (irq),
    .d2e_fire     (d2e_fire),
    .e2f_fire     (e2f_fire)
);

// File: tb/chstat_blkbuf_bench.sv
module chstat_blkbuf_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BLK  = 192;
    localparam int NB   = 24;
    localparam int BASE = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       rx_valid = 1'b0, rx_blk_start = 1'b0, rx_ch_a = 1'b0, rx_ch_b = 1'b0;
    logic       tx_frame_req = 1'b0, tx_blk_start = 1'b0;
    logic       tx_ch_a, tx_ch_b;
    logic [6:0] host_addr = '0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       hold_rx2host = 1'b0, hold_host2tx = 1'b0;
    logic [1:0] evt_en = '0, evt_clr = '0;
    logic [1:0] evt_stat;
    logic       irq;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;
    bit  exp_e [2][BLK];
    bit  exp_f [2][BLK];

    always #(CLK_PERIOD/2) clk = ~clk;

    chstat_blkbuf u_chstat_blkbuf (
        .clk(clk), .rst_n(rst_n), .run_en(run_en),
        .rx_valid(rx_valid), .rx_blk_start(rx_blk_start), .rx_ch_a(rx_ch_a), .rx_ch_b(rx_ch_b),
        .tx_frame_req(tx_frame_req), .tx_blk_start(tx_blk_start),
        .tx_ch_a(tx_ch_a), .tx_ch_b(tx_ch_b),
        .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .hold_rx2host(hold_rx2host), .hold_host2tx(hold_host2tx),
        .evt_en(evt_en), .evt_clr(evt_clr), .evt_stat(evt_stat), .irq(irq)
    );

    function automatic bit pbit(int blk, int ch, int f);
        return ((f*f + 3*f + blk*11 + ch*29) % 7) < 3;
    endfunction

    function automatic logic [7:0] exp_byte(int ch, int k);
        logic [7:0] v;
        for (int i = 0; i < 8; i++) v[7-i] = exp_e[ch][8*k+i];
        return v;
    endfunction

    task automatic set_byte(int ch, int k, logic [7:0] v);
        for (int i = 0; i < 8; i++) exp_e[ch][8*k+i] = v[7-i];
    endtask

    task automatic load_pattern(int blk);
        for (int ch = 0; ch < 2; ch++)
            for (int f = 0; f < BLK; f++) exp_e[ch][f] = pbit(blk, ch, f);
    endtask

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic read_chk(int a, logic [7:0] expv, string req);
        @(negedge clk);
        host_addr = 7'(a);
        #1;
        chk(req, int'(host_rdata), int'(expv));
    endtask

    task automatic sweep_window(string req);
        for (int ch = 0; ch < 2; ch++)
            for (int k = 0; k < NB; k++)
                read_chk(BASE + NB*ch + k, exp_byte(ch, k), req);
    endtask

    task automatic hwrite(int a, logic [7:0] d);
        @(negedge clk);
        host_addr = 7'(a); host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rx_frame(bit start, bit a, bit b);
        @(negedge clk);
        rx_valid = 1'b1; rx_blk_start = start; rx_ch_a = a; rx_ch_b = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_blk_start = 1'b0;
    endtask

    task automatic rx_body(int blk, int from, int upto);
        for (int f = from; f <= upto; f++) rx_frame(1'b0, pbit(blk, 0, f), pbit(blk, 1, f));
    endtask

    task automatic tx_frame(bit start);
        @(negedge clk);
        tx_frame_req = 1'b1; tx_blk_start = start;
        @(negedge clk);
        tx_frame_req = 1'b0; tx_blk_start = 1'b0;
        #1;
    endtask

    task automatic tx_block_chk(string req);
        tx_frame(1'b1);
        chk(req, int'({tx_ch_a, tx_ch_b}), int'({exp_f[0][0], exp_f[1][0]}));
        for (int f = 1; f <= BLK + 1; f++) begin
            tx_frame(1'b0);
            chk(req, int'({tx_ch_a, tx_ch_b}), int'({exp_f[0][f % BLK], exp_f[1][f % BLK]}));
        end
    endtask

    task automatic clr_pulse(logic [1:0] v);
        @(negedge clk);
        evt_clr = v;
        @(negedge clk);
        evt_clr = 2'b00;
        #1;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int ch = 0; ch < 2; ch++)
            for (int f = 0; f < BLK; f++) begin exp_e[ch][f] = 0; exp_f[ch][f] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_en = 1'b1;
        evt_en = 2'b01;

        // R1: reset state, whole address space reads zero
        for (int a = 0; a < 128; a++) read_chk(a, 8'h00, "R1 reset read");
        chk("R1 evt_stat", int'(evt_stat), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 tx bits", int'({tx_ch_a, tx_ch_b}), 0);
        tx_frame(1'b0);
        chk("R8 idle output", int'({tx_ch_a, tx_ch_b}), 0);

        // R3: stray frames, then an incomplete block
        rx_body(0, 0, 9);
        rx_frame(1'b1, pbit(0, 0, 0), pbit(0, 1, 0));
        rx_body(0, 1, 99);
        rx_frame(1'b1, pbit(1, 0, 0), pbit(1, 1, 0));
        #1;
        chk("R3 early start no copy", int'(evt_stat), 0);
        read_chk(32, 8'h00, "R3 host store untouched");
        read_chk(79, 8'h00, "R3 host store untouched");
        rx_body(1, 1, 191);
        chk("R3 no copy before boundary", int'(evt_stat), 0);

        // R2: complete block then boundary copies
        rx_frame(1'b1, pbit(2, 0, 0), pbit(2, 1, 0));
        #1;
        load_pattern(1);
        chk("R2 copy flag", int'(evt_stat), 1);
        chk("R11 irq enabled event", int'(irq), 1);
        sweep_window("R4 byte map");
        repeat (5) @(negedge clk);
        #1;
        chk("R10 sticky", int'(evt_stat), 1);
        clr_pulse(2'b01);
        chk("R10 cleared", int'(evt_stat), 0);
        chk("R11 irq low", int'(irq), 0);

        // R6: run gate
        run_en = 1'b0;
        read_chk(32, 8'h00, "R6 gated read");
        read_chk(60, 8'h00, "R6 gated read");
        hwrite(33, 8'hC3);
        run_en = 1'b1;
        read_chk(33, exp_byte(0, 1), "R6 write ignored");

        // R5: outside window
        hwrite(31, 8'hFF);
        hwrite(80, 8'hFF);
        hwrite(127, 8'hFF);
        hwrite(0, 8'hFF);
        for (int a = 0; a < 32; a++) read_chk(a, 8'h00, "R5 low reads zero");
        for (int a = 80; a < 128; a++) read_chk(a, 8'h00, "R5 high reads zero");
        sweep_window("R5 store unchanged");

        // R7: host writes at window edges
        hwrite(32, 8'h5A); set_byte(0, 0, 8'h5A);
        hwrite(55, 8'h81); set_byte(0, 23, 8'h81);
        hwrite(56, 8'h3C); set_byte(1, 0, 8'h3C);
        hwrite(79, 8'hE7); set_byte(1, 23, 8'hE7);
        sweep_window("R7 host write");

        // R8: copy to transmit store and serialize
        for (int ch = 0; ch < 2; ch++)
            for (int f = 0; f < BLK; f++) exp_f[ch][f] = exp_e[ch][f];
        tx_block_chk("R8 serial order");
        chk("R10 tx copy flag", int'(evt_stat), 2);
        chk("R11 irq masked", int'(irq), 0);
        evt_en = 2'b11;
        #1;
        chk("R11 irq unmasked", int'(irq), 1);
        clr_pulse(2'b11);

        // R9: held capture-to-host copy is dropped
        rx_body(2, 1, 191);
        hold_rx2host = 1'b1;
        rx_frame(1'b1, pbit(3, 0, 0), pbit(3, 1, 0));
        hold_rx2host = 1'b0;
        #1;
        chk("R9 held no flag", int'(evt_stat), 0);
        sweep_window("R9 host store kept");
        repeat (4) @(negedge clk);
        #1;
        chk("R9 not deferred", int'(evt_stat), 0);

        // R7: copy beats a same-cycle host write
        rx_body(3, 1, 191);
        @(negedge clk);
        rx_valid = 1'b1; rx_blk_start = 1'b1;
        rx_ch_a = pbit(4, 0, 0); rx_ch_b = pbit(4, 1, 0);
        host_addr = 7'd40; host_wdata = 8'hFF; host_wr = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_blk_start = 1'b0; host_wr = 1'b0;
        #1;
        load_pattern(3);
        chk("R2 copy flag", int'(evt_stat), 1);
        sweep_window("R7 copy wins");
        clr_pulse(2'b01);

        // R9: held host-to-transmit copy, old block keeps playing
        hold_host2tx = 1'b1;
        tx_block_chk("R9 tx store kept");
        hold_host2tx = 1'b0;
        chk("R9 tx held no flag", int'(evt_stat), 0);

        // R10: set wins over clear in the same cycle
        @(negedge clk);
        tx_frame_req = 1'b1; tx_blk_start = 1'b1; evt_clr = 2'b10;
        @(negedge clk);
        tx_frame_req = 1'b0; tx_blk_start = 1'b0; evt_clr = 2'b00;
        #1;
        chk("R10 set wins", int'(evt_stat), 2);
        for (int ch = 0; ch < 2; ch++)
            for (int f = 0; f < BLK; f++) exp_f[ch][f] = exp_e[ch][f];
        chk("R8 new block frame 0", int'({tx_ch_a, tx_ch_b}), int'({exp_f[0][0], exp_f[1][0]}));
        for (int f = 1; f < 6; f++) begin
            tx_frame(1'b0);
            chk("R8 new block frames", int'({tx_ch_a, tx_ch_b}), int'({exp_f[0][f], exp_f[1][f]}));
        end

        done = 1;
        summary();
        $finish;
    end

endmodule